// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block collects thirteen level-sensitive interrupt sources, numbered 1 to 13, and presents the most urgent one to a processor as a 3-bit interrupt level and an 8-bit vector number. Each source has its own 8-bit control byte. The control byte holds a 3-bit level (bits 4:2), a 2-bit priority within that level (bits 1:0) and an autovector enable (bit 7). A 16-bit mask register can block each source. Only sources that are asserted and unmasked take part in arbitration.

The winner is the active source with the largest 5-bit rank {level, priority}. A winner whose level is 0 produces no interrupt. The vector is either 24 plus the level (autovector), or it is read from a per-source vector register. Three sources have such a register: a watchdog source and two serial-port sources. Every other source falls back to a fixed code. Software programs the block through a single-cycle byte/halfword register bus with no wait states and no back-pressure. A request is accepted in the cycle that `bus_sel` is high. Read data is registered and appears on the next cycle.

Top module: `prio_vec_intc`

## Requirements
- R1: Bit i of the pending register (halfword at 0x3A) is the value of source i sampled at the last clock edge. Bits 0, 14 and 15 read 0. Writes to 0x3A and 0x3B change nothing.
- R2: The mask register is a halfword at 0x36. A 1 in bit i blocks source i. It resets to 0x3FFE. A byte access to 0x36 reaches bits 15:8, and a byte access to 0x37 reaches bits 7:0.
- R3: The winner is the active (asserted, unmasked) source whose control bits 4:0 are the largest. On equal values the lower-numbered source wins.
- R4: If no source is active, or the winner's control bits 4:0 are below 4, both the level output and the vector output are 0.
- R5: The level output is the winner's control bits 4:2. If the winner's bit 7 is set, the vector is 24 plus that level.
- R6: If the winner's bit 7 is clear, the vector comes from a register. Source 8 uses the watchdog vector register at byte 0x42. Source 12 uses serial vector 0 at 0x44, and source 13 uses serial vector 1 at 0x45. Any other source gives 0x0F.
- R7: Control bytes reset to these values: 0x04, 0x08, 0x0C, 0x10, 0x14, 0x18 and 0x1C for sources 1 to 7; 0x1C for source 8; 0x80 for sources 9 to 11; 0x00 for sources 12 and 13. The watchdog vector resets to 0x0F and both serial vectors reset to 0x00.
- R8: The control byte of source i sits at byte address 0x13+i. A halfword access uses the even address below it. The even byte maps to data bits 15:8 and the odd byte maps to bits 7:0. A byte read returns its value in bits 7:0 with bits 15:8 zero.
- R9: The level and vector outputs are registered. They change at the first clock edge after a source input changes, or at the first edge after a register write has taken effect. An unmapped address reads 0, and a write to it has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| src_i | input | 13 | Source request levels, bit i is source i (i = 1..13) |
| bus_sel | input | 1 | Register access this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_hw | input | 1 | 1 = halfword access, 0 = byte access |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 16 | Write data (byte writes use bits 7:0) |
| bus_rdata | output | 16 | Read data, loaded at the edge that accepts a read |
| irq_level_o | output | 3 | Presented interrupt level, 0 = none |
| irq_vector_o | output | 8 | Presented vector number |

## Verification
Several properties are checked by assertions on every cycle. The pending register must track the source inputs with a one-edge delay. The mask must hold its value when no write occurs. A level-0 output must always come with a zero vector. An interrupt may appear only when some source was active in the cycle before. Other behaviour can only be shown by the bench's scenarios. These scenarios cover the ranking and its lowest-number tie rule, the suppression of level-0 winners, the choice between autovector, per-source vector register and the fixed code, the reset contents, the big-endian byte lanes of halfword accesses, and the exact edge at which the outputs follow an input change.

// File: rtl/pvi_pkg.sv
package pvi_pkg;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 16;
  localparam int RANK_W = 5;
  localparam int LVL_W  = 3;
  localparam int VEC_W  = 8;

  // register byte addresses
  localparam logic [ADDR_W-1:0] CTRL_BASE = 8'h13;  // source i at CTRL_BASE + i
  localparam logic [ADDR_W-1:0] MASK_ADDR = 8'h36;
  localparam logic [ADDR_W-1:0] PEND_ADDR = 8'h3A;
  localparam logic [ADDR_W-1:0] WDV_ADDR  = 8'h42;
  localparam logic [ADDR_W-1:0] SV0_ADDR  = 8'h44;
  localparam logic [ADDR_W-1:0] SV1_ADDR  = 8'h45;

  localparam logic [DATA_W-1:0] MASK_RST = 16'h3FFE;
  localparam logic [VEC_W-1:0]  WDV_RST  = 8'h0F;
  localparam logic [VEC_W-1:0]  SV_RST   = 8'h00;
  localparam logic [VEC_W-1:0]  FALLBACK_VEC = 8'h0F;

  // control byte reset value for source idx
  function automatic logic [7:0] ctrl_rst(input int idx);
    if (idx >= 1 && idx <= 7) return 8'(idx * 4);
    if (idx == 8)             return 8'h1C;
    if (idx >= 9 && idx <= 11) return 8'h80;
    return 8'h00;
  endfunction
endpackage

// File: rtl/pvi_regs.sv
module pvi_regs
  import pvi_pkg::*;
#(
  parameter int NSRC = 13
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NSRC:1]            src_i,
  input  logic                     bus_sel,
  input  logic                     bus_we,
  input  logic                     bus_hw,
  input  logic [ADDR_W-1:0]        bus_addr,
  input  logic [DATA_W-1:0]        bus_wdata,
  output logic [DATA_W-1:0]        bus_rdata,
  output logic [NSRC:1][7:0]       ctrl_o,
  output logic [DATA_W-1:0]        mask_o,
  output logic [VEC_W-1:0]         wdv_o,
  output logic [VEC_W-1:0]         sv0_o,
  output logic [VEC_W-1:0]         sv1_o
);
  localparam int LANES = 2;

  logic [NSRC:1][7:0] ctrl_q;
  logic [DATA_W-1:0]  mask_q, pend_q;
  logic [VEC_W-1:0]   wdv_q, sv0_q, sv1_q;

  // byte lanes: lane 0 = addressed (or even) byte, lane 1 = odd byte of a halfword
  logic [LANES-1:0]             lane_en;
  logic [LANES-1:0][ADDR_W-1:0] lane_addr;
  logic [LANES-1:0][7:0]        lane_data;

  always_comb begin
    lane_en[0]   = bus_sel && bus_we;
    lane_en[1]   = bus_sel && bus_we && bus_hw;
    lane_addr[0] = bus_hw ? {bus_addr[ADDR_W-1:1], 1'b0} : bus_addr;
    lane_addr[1] = {bus_addr[ADDR_W-1:1], 1'b1};
    lane_data[0] = bus_hw ? bus_wdata[15:8] : bus_wdata[7:0];
    lane_data[1] = bus_wdata[7:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 1; i <= NSRC; i++) ctrl_q[i] <= ctrl_rst(i);
      mask_q <= MASK_RST;
      wdv_q  <= WDV_RST;
      sv0_q  <= SV_RST;
      sv1_q  <= SV_RST;
    end else begin
      for (int l = 0; l < LANES; l++) begin
        if (lane_en[l]) begin
          for (int i = 1; i <= NSRC; i++)
            if (lane_addr[l] == CTRL_BASE + 8'(i)) ctrl_q[i] <= lane_data[l];
          if (lane_addr[l] == MASK_ADDR)        mask_q[15:8] <= lane_data[l];
          if (lane_addr[l] == MASK_ADDR + 8'd1) mask_q[7:0]  <= lane_data[l];
          if (lane_addr[l] == WDV_ADDR)         wdv_q <= lane_data[l];
          if (lane_addr[l] == SV0_ADDR)         sv0_q <= lane_data[l];
          if (lane_addr[l] == SV1_ADDR)         sv1_q <= lane_data[l];
        end
      end
    end
  end

  // pending mirrors the sources; bus writes never reach it
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= DATA_W'({src_i, 1'b0});
  end

  function automatic logic [7:0] rd_byte(input logic [ADDR_W-1:0] a);
    logic [7:0] r;
    r = 8'h00;
    for (int i = 1; i <= NSRC; i++)
      if (a == CTRL_BASE + 8'(i)) r = ctrl_q[i];
    if (a == MASK_ADDR)        r = mask_q[15:8];
    if (a == MASK_ADDR + 8'd1) r = mask_q[7:0];
    if (a == PEND_ADDR)        r = pend_q[15:8];
    if (a == PEND_ADDR + 8'd1) r = pend_q[7:0];
    if (a == WDV_ADDR)         r = wdv_q;
    if (a == SV0_ADDR)         r = sv0_q;
    if (a == SV1_ADDR)         r = sv1_q;
    return r;
  endfunction

  logic [DATA_W-1:0] rd_next;
  always_comb begin
    if (bus_hw) rd_next = {rd_byte(lane_addr[0]), rd_byte(lane_addr[1])};
    else        rd_next = {8'h00, rd_byte(bus_addr)};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  bus_rdata <= '0;
    else if (bus_sel && !bus_we) bus_rdata <= rd_next;
  end

  assign ctrl_o = ctrl_q;
  assign mask_o = mask_q;
  assign wdv_o  = wdv_q;
  assign sv0_o  = sv0_q;
  assign sv1_o  = sv1_q;

  // R1
  pend_mirror_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> pend_q[NSRC:1] == $past(src_i));

  // R2
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_sel && bus_we) |=> $stable(mask_q));
endmodule

// File: rtl/pvi_arbiter.sv
module pvi_arbiter
  import pvi_pkg::*;
#(
  parameter int NSRC = 13,
  localparam int IDW = $clog2(NSRC + 1)
) (
  input  logic [NSRC:1]      active_i,
  input  logic [NSRC:1][7:0] ctrl_i,
  output logic [IDW-1:0]     win_id_o,
  output logic [7:0]         win_ctrl_o,
  output logic               win_ok_o
);
  localparam logic [RANK_W-1:0] MIN_RANK = RANK_W'(4);  // level field non-zero

  logic [RANK_W-1:0] best_rank;

  // ascending scan with strict compare: ties keep the lower source number
  always_comb begin
    best_rank  = '0;
    win_id_o   = '0;
    win_ctrl_o = '0;
    for (int i = 1; i <= NSRC; i++) begin
      if (active_i[i] && ctrl_i[i][RANK_W-1:0] > best_rank) begin
        best_rank  = ctrl_i[i][RANK_W-1:0];
        win_id_o   = IDW'(i);
        win_ctrl_o = ctrl_i[i];
      end
    end
    win_ok_o = best_rank >= MIN_RANK;
  end
endmodule

// File: rtl/pvi_vector.sv
module pvi_vector
  import pvi_pkg::*;
#(
  parameter int NSRC      = 13,
  parameter int WDOG_SRC  = 8,
  parameter int SER0_SRC  = 12,
  parameter int SER1_SRC  = 13,
  parameter int AUTO_BASE = 24,
  localparam int IDW = $clog2(NSRC + 1)
) (
  input  logic [IDW-1:0]   win_id_i,
  input  logic [7:0]       win_ctrl_i,
  input  logic             win_ok_i,
  input  logic [VEC_W-1:0] wdv_i,
  input  logic [VEC_W-1:0] sv0_i,
  input  logic [VEC_W-1:0] sv1_i,
  output logic [LVL_W-1:0] level_o,
  output logic [VEC_W-1:0] vector_o
);
  logic [LVL_W-1:0] lvl;
  assign lvl = win_ctrl_i[4:2];

  always_comb begin
    level_o  = '0;
    vector_o = '0;
    if (win_ok_i) begin
      level_o = lvl;
      if (win_ctrl_i[7])                      vector_o = VEC_W'(AUTO_BASE) + VEC_W'(lvl);
      else if (win_id_i == IDW'(WDOG_SRC))    vector_o = wdv_i;
      else if (win_id_i == IDW'(SER0_SRC))    vector_o = sv0_i;
      else if (win_id_i == IDW'(SER1_SRC))    vector_o = sv1_i;
      else                                    vector_o = FALLBACK_VEC;
    end
  end
endmodule

// File: rtl/prio_vec_intc.sv
module prio_vec_intc
  import pvi_pkg::*;
#(
  parameter int NSRC      = 13,
  parameter int WDOG_SRC  = 8,
  parameter int SER0_SRC  = 12,
  parameter int SER1_SRC  = 13,
  parameter int AUTO_BASE = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC:1]     src_i,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic              bus_hw,
  input  logic [7:0]        bus_addr,
  input  logic [15:0]       bus_wdata,
  output logic [15:0]       bus_rdata,
  output logic [2:0]        irq_level_o,
  output logic [7:0]        irq_vector_o
);
  localparam int IDW = $clog2(NSRC + 1);

  logic [NSRC:1][7:0] ctrl;
  logic [DATA_W-1:0]  mask;
  logic [VEC_W-1:0]   wdv, sv0, sv1;
  logic [NSRC:1]      active;
  logic [IDW-1:0]     win_id;
  logic [7:0]         win_ctrl;
  logic               win_ok;
  logic [LVL_W-1:0]   lvl_d;
  logic [VEC_W-1:0]   vec_d;

  pvi_regs #(.NSRC(NSRC)) u_regs (
    .clk(clk), .rst_n(rst_n), .src_i(src_i),
    .bus_sel(bus_sel), .bus_we(bus_we), .bus_hw(bus_hw),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ctrl_o(ctrl), .mask_o(mask), .wdv_o(wdv), .sv0_o(sv0), .sv1_o(sv1)
  );

  assign active = src_i & ~mask[NSRC:1];

  pvi_arbiter #(.NSRC(NSRC)) u_arb (
    .active_i(active), .ctrl_i(ctrl),
    .win_id_o(win_id), .win_ctrl_o(win_ctrl), .win_ok_o(win_ok)
  );

  pvi_vector #(
    .NSRC(NSRC), .WDOG_SRC(WDOG_SRC), .SER0_SRC(SER0_SRC),
    .SER1_SRC(SER1_SRC), .AUTO_BASE(AUTO_BASE)
  ) u_vec (
    .win_id_i(win_id), .win_ctrl_i(win_ctrl), .win_ok_i(win_ok),
    .wdv_i(wdv), .sv0_i(sv0), .sv1_i(sv1),
    .level_o(lvl_d), .vector_o(vec_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_level_o  <= '0;
      irq_vector_o <= '0;
    end else begin
      irq_level_o  <= lvl_d;
      irq_vector_o <= vec_d;
    end
  end

  // R4
  idle_vec_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_level_o == 3'd0 |-> irq_vector_o == 8'd0);

  // R3
  no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_level_o != 3'd0 |-> $past(|active));
endmodule

// File: tb/sim_prio_vec_intc.sv
module sim_prio_vec_intc;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [13:1] src = '0;
  logic        sel = 1'b0, we = 1'b0, hw = 1'b0;
  logic [7:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic [2:0]  lvl;
  logic [7:0]  vec;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  prio_vec_intc u0 (
    .clk(clk), .rst_n(rst_n), .src_i(src),
    .bus_sel(sel), .bus_we(we), .bus_hw(hw), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rdata),
    .irq_level_o(lvl), .irq_vector_o(vec)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input bit half, input logic [15:0] d);
    @(negedge clk);
    sel = 1'b1; we = 1'b1; hw = half; addr = a; wdata = d;
    @(negedge clk);
    sel = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input bit half, output logic [15:0] d);
    @(negedge clk);
    sel = 1'b1; we = 1'b0; hw = half; addr = a;
    @(negedge clk);
    d = rdata;
    sel = 1'b0;
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  task automatic chk_out(input string req, input logic [2:0] el, input logic [7:0] ev);
    chk({req, " level"}, 16'(lvl), 16'(el));
    chk({req, " vector"}, 16'(vec), 16'(ev));
  endtask

  task automatic t_reset();
    logic [15:0] d;
    chk_out("R4 reset", 3'd0, 8'h00);
    rd(8'h36, 1, d); chk("R2 mask reset", d, 16'h3FFE);
    rd(8'h14, 1, d); chk("R7 R8 ctrl1/2 reset", d, 16'h0408);
    rd(8'h1A, 1, d); chk("R7 ctrl7/8 reset", d, 16'h1C1C);
    rd(8'h1E, 1, d); chk("R7 ctrl11/12 reset", d, 16'h8000);
    rd(8'h1C, 0, d); chk("R8 byte read ctrl9", d, 16'h0080);
    rd(8'h42, 0, d); chk("R7 watchdog vector reset", d, 16'h000F);
    rd(8'h45, 0, d); chk("R7 serial vector reset", d, 16'h0000);
  endtask

  task automatic t_mask_and_tie();
    logic [15:0] d;
    @(negedge clk); src = 13'h1FFF; settle();
    chk_out("R2 all masked", 3'd0, 8'h00);
    rd(8'h3A, 1, d); chk("R1 pending all", d, 16'h3FFE);
    wr(8'h36, 1, 16'h0000); settle();
    chk_out("R3 tie 7 vs 8 lowest wins", 3'd7, 8'h0F);
    @(negedge clk); src = '0; src[8] = 1'b1; settle();
    chk_out("R6 source 8 watchdog reset vec", 3'd7, 8'h0F);
    wr(8'h42, 0, 16'h0040); settle();
    chk_out("R6 source 8 watchdog vec", 3'd7, 8'h40);
    rd(8'h3A, 1, d); chk("R1 pending one source", d, 16'h0100);
  endtask

  task automatic t_rank();
    @(negedge clk); src = '0; src[3] = 1'b1; src[5] = 1'b1; settle();
    chk_out("R3 R5 higher rank wins", 3'd5, 8'h0F);
    wr(8'h16, 0, 16'h001F); settle();
    chk_out("R3 priority bits raise source 3", 3'd7, 8'h0F);
    wr(8'h16, 0, 16'h0003); settle();
    chk_out("R3 source 5 after demotion", 3'd5, 8'h0F);
    @(negedge clk); src = '0; src[3] = 1'b1; settle();
    chk_out("R4 level 0 winner suppressed", 3'd0, 8'h00);
  endtask

  task automatic t_autovec();
    @(negedge clk); src = '0; src[9] = 1'b1; settle();
    chk_out("R4 rank 0 autovector source", 3'd0, 8'h00);
    wr(8'h1C, 0, 16'h008E); settle();
    chk_out("R5 autovector 24+3", 3'd3, 8'h1B);
  endtask

  task automatic t_serial();
    logic [15:0] d;
    wr(8'h1E, 1, 16'h8E18);
    wr(8'h20, 0, 16'h0019);
    wr(8'h44, 1, 16'h6677);
    @(negedge clk); src = '0; src[12] = 1'b1; settle();
    chk_out("R6 R8 serial 0 vec", 3'd6, 8'h66);
    @(negedge clk); src[13] = 1'b1; settle();
    chk_out("R6 serial 1 vec", 3'd6, 8'h77);
    wr(8'h36, 0, 16'h0020); settle();
    chk_out("R2 byte mask blocks 13", 3'd6, 8'h66);
    rd(8'h36, 1, d); chk("R2 mask after byte write", d, 16'h2000);
    rd(8'h1F, 0, d); chk("R8 odd byte of halfword write", d, 16'h0018);
  endtask

  task automatic t_timing();
    logic [15:0] d;
    wr(8'h36, 1, 16'h0000);
    @(negedge clk); src = '0; settle();
    chk_out("R9 idle", 3'd0, 8'h00);
    @(negedge clk); src[12] = 1'b1;
    #1 chk("R9 no change before edge", 16'(lvl), 16'h0000);
    @(posedge clk); #1;
    chk_out("R9 one edge latency", 3'd6, 8'h66);
    wr(8'h3A, 1, 16'hFFFF);
    rd(8'h3A, 1, d); chk("R1 pending write ignored", d, 16'h1000);
    rd(8'h50, 1, d); chk("R9 unmapped read", d, 16'h0000);
    wr(8'h50, 1, 16'hFFFF); settle();
    chk_out("R9 unmapped write no effect", 3'd6, 8'h66);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_mask_and_tie();
    t_rank();
    t_autovec();
    t_serial();
    t_timing();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule